// File: doc/BRIEF.md
# Background Sequential 8x8 Multiplier

This block multiplies two unsigned 8-bit operands into a 16-bit product while the host processor keeps running. The host writes the multiplicand and then the multiplier through a small register port; the write of the multiplier starts the operation. After that, each cycle in which the step enable is high resolves one multiplier bit. Eight such steps complete the product.

The product register can be read at any moment. A read taken before the eighth step returns the partial sum built so far, one bit-step at a time. The steps use a radix-2 Booth recoding of the multiplier, so a partial value may be a modulo-2^16 image of a negative sum. A busy flag shows when an operation is still running. A new start during a running operation discards it and begins again with the new operands.

Top module: `bg_mul8`

## Requirements
- R1: After reset `product` is 0 and `busy` is 0.
- R2: A write with `wr_sel`=0 loads `wr_data` into the multiplicand holding register. It changes neither `product` nor `busy`.
- R3: A write with `wr_sel`=1 is a start. It latches `wr_data` as the multiplier and the holding register as the working multiplicand. It clears the step count and the previous-bit flag. From the next cycle `product` is 0 and `busy` is 1.
- R4: Each cycle with `step_en`=1 while busy performs step i, where i counts 0..7, and the result is seen on `product` the next cycle. Step i uses the bit pair (cur=b[i], prev=b[i-1]), with b[-1]=0. For i<7, pair 01 adds A<<i, pair 10 subtracts A<<i, and pairs 00 and 11 do nothing. Step 7 adds (cur+prev)*(A<<7). All arithmetic is modulo 2^16.
- R5: While busy, a cycle with `step_en`=0 and no start leaves `product`, `busy` and the step count unchanged.
- R6: The first step may occur on the cycle right after the start. After the eighth step `busy` falls and `product` equals A*B exactly.
- R7: While idle, `step_en` has no effect on `product` or `busy`.
- R8: A start while busy aborts the running operation and begins again from step 0 with the new operands.
- R9: A multiplicand write while busy does not alter the running operation. It is used at the next start.
- R10: When a start and `step_en` occur in the same cycle, the start wins and no step is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: multiplicand register, 1: multiplier register (start) |
| wr_data | input | W | Write data |
| step_en | input | 1 | Marks a computation cycle |
| product | output | 2W | Product register, partial while busy |
| busy | output | 1 | High from start until the eighth step |

## Verification
A wrong step count or a wrong previous-bit flag changes the Booth pair that is examined. That shows on `product` in the cycle after the faulty step, because every step is visible at the port and the bench compares every cycle against its model. A wrong latch of an operand shows on the first step after the start that uses it. A stuck or early busy shows within one cycle of the eighth step, as `busy` against the expected flag or as a missing or extra update to `product`.

// File: rtl/bg_mul8.sv
module bg_mul8 #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_sel,
  input  logic [W-1:0]   wr_data,
  input  logic           step_en,
  output logic [2*W-1:0] product,
  output logic           busy
);
  localparam int PW = 2 * W;
  localparam int SW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  hold_q, mc_q, mp_q;
  logic [PW-1:0] acc_q, shifted, delta;
  logic [SW-1:0] step_q;
  logic          pbit_q, busy_q;

  wire start = wr_en & wr_sel;
  wire load  = wr_en & ~wr_sel;
  wire adv   = busy_q & step_en & ~start;
  wire cur   = mp_q[step_q];
  wire last  = (step_q == SW'(W - 1));

  assign shifted = PW'(mc_q) << step_q;

  always_comb begin
    delta = '0;
    if (last) begin
      case ({cur, pbit_q})
        2'b01, 2'b10: delta = shifted;
        2'b11:        delta = shifted << 1;
        default:      delta = '0;
      endcase
    end else begin
      case ({cur, pbit_q})
        2'b01:   delta = shifted;
        2'b10:   delta = ~shifted + PW'(1);
        default: delta = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      mc_q   <= '0;
      mp_q   <= '0;
      acc_q  <= '0;
      step_q <= '0;
      pbit_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (load) hold_q <= wr_data;
      if (start) begin
        mc_q   <= hold_q;
        mp_q   <= wr_data;
        acc_q  <= '0;
        step_q <= '0;
        pbit_q <= 1'b0;
        busy_q <= 1'b1;
      end else if (adv) begin
        acc_q  <= acc_q + delta;
        step_q <= step_q + SW'(1);
        pbit_q <= cur;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign product = acc_q;
  assign busy    = busy_q;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && product == '0)); // R3
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_en && !start) |=> ($stable(product) && busy)); // R5
  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(product) && !busy)); // R7
  AST_FINAL_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (product == PW'(PW'(mc_q) * PW'(mp_q)))); // R6
  AST_LOAD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !busy) |=> (!busy && $stable(product))); // R2
endmodule

// File: tb/bg_mul8_test.sv
`timescale 1ns/1ps
module bg_mul8_test;
  logic clk = 0, rst_n = 0, wr_en = 0, wr_sel = 0, step_en = 0;
  logic [7:0] wr_data = 0;
  logic [15:0] product;
  logic busy;
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  bg_mul8 #(.W(8)) uut (.clk, .rst_n, .wr_en, .wr_sel, .wr_data, .step_en, .product, .busy);

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  int    q_tgt[$];
  logic [16:0] q_val[$];
  string q_tag[$];

  logic [7:0]  m_hold = 0, m_mc = 0, m_mp = 0;
  logic [15:0] m_acc = 0;
  int          m_step = 0;
  logic        m_pb = 0, m_busy = 0;

  task automatic check(string tag, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s busy/product actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    #2;
    while (q_tgt.size() > 0 && q_tgt[0] == cyc) begin
      check(q_tag[0], {busy, product}, q_val[0]);
      void'(q_tgt.pop_front()); void'(q_val.pop_front()); void'(q_tag.pop_front());
    end
  end

  // drive one cycle (called at posedge+1), model its effect, push expectation
  task automatic tick(logic we, logic sel, logic [7:0] d, logic en);
    string tag;
    int delta;
    logic cur;
    wr_en = we; wr_sel = sel; wr_data = d; step_en = en;
    if (we && sel) begin
      tag = m_busy ? "R8" : (en ? "R10" : "R3");
      m_mc = m_hold; m_mp = d; m_acc = 0; m_step = 0; m_pb = 0; m_busy = 1;
    end else if (m_busy && en) begin
      cur = m_mp[m_step];
      if (m_step == 7) delta = (int'(cur) + int'(m_pb)) * (int'(m_mc) << 7);
      else             delta = (int'(m_pb) - int'(cur)) * (int'(m_mc) << m_step);
      m_acc = 16'(int'(m_acc) + delta);
      m_pb = cur;
      tag = "R4";
      if (m_step == 7) begin
        m_busy = 0; tag = "R6";
        if (m_acc !== 16'(m_mc * m_mp)) tag = "R6 model";
      end
      m_step++;
      if (we) tag = "R9";
    end else if (m_busy) tag = we ? "R9" : "R5";
    else if (we) tag = "R2";
    else tag = en ? "R7" : "R1";
    if (we && !sel) m_hold = d;
    q_tgt.push_back(cyc + 1); q_val.push_back({m_busy, m_acc}); q_tag.push_back(tag);
    @(posedge clk); #1;
  endtask

  task automatic run_op(logic [7:0] a, logic [7:0] b, int gap);
    int k = 0;
    tick(1, 0, a, 0);
    tick(1, 1, b, 0);
    while (m_busy) begin
      tick(0, 0, 0, (gap == 0) || ((k % gap) != gap - 1));
      k++;
    end
    check("R6 exact", {1'b0, product}, {1'b0, 16'(a * b)});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset", {busy, product}, 17'h0);
    rst_n = 1;
    @(posedge clk); #1;
    tick(0, 0, 0, 1); tick(0, 0, 0, 1);          // R7 idle step_en
    tick(1, 0, 8'hC3, 0);                         // R2 load only
    run_op(8'hFF, 8'hFF, 0);                      // R6 corner
    run_op(8'h00, 8'hFF, 0);
    run_op(8'hA5, 8'h5A, 3);                      // R5 gaps
    // R8 restart mid-operation
    tick(1, 0, 8'h37, 0); tick(1, 1, 8'hB6, 0);
    tick(0, 0, 0, 1); tick(0, 0, 0, 1); tick(0, 0, 0, 1);
    tick(1, 0, 8'h91, 0); tick(1, 1, 8'h6D, 0);
    while (m_busy) tick(0, 0, 0, 1);
    check("R8 exact", {1'b0, product}, {1'b0, 16'(8'h91 * 8'h6D)});
    // R9 multiplicand write during operation
    tick(1, 0, 8'h2B, 0); tick(1, 1, 8'hE7, 0);
    tick(0, 0, 0, 1); tick(1, 0, 8'hF0, 1); tick(1, 0, 8'h0F, 0);
    while (m_busy) tick(0, 0, 0, 1);
    check("R9 exact", {1'b0, product}, {1'b0, 16'(8'h2B * 8'hE7)});
    tick(1, 1, 8'h03, 0);
    while (m_busy) tick(0, 0, 0, 1);
    check("R9 next start", {1'b0, product}, {1'b0, 16'(8'h0F * 8'h03)});
    // R10 start with step_en in the same cycle
    tick(1, 0, 8'h81, 0); tick(1, 1, 8'h7E, 1);
    while (m_busy) tick(0, 0, 0, 1);
    check("R10 exact", {1'b0, product}, {1'b0, 16'(8'h81 * 8'h7E)});
    // R4 sweep: every multiplier against 16 multiplicands
    for (int a = 0; a < 256; a += 17)
      for (int b = 0; b < 256; b++)
        run_op(8'(a), 8'(b), (b % 7 == 0) ? 2 : 0);
    tick(0, 0, 0, 0); tick(0, 0, 0, 0);
    finish_run();
  end
endmodule